// File: doc/BRIEF.md
# DRAM Command Decoder and Legality Checker

This block watches the command pins of a double-data-rate DRAM on every rising clock edge. It turns the chip-select, the three strobes, clock-enable, the bank-address bits and A10 into one command per cycle. It keeps a small state machine for each bank, and it flags any command that the current bank or device state does not allow. It sits beside a memory controller or a memory model as a protocol monitor. It has no data path and no handshake: every input is a plain sampled pin, and every output is a registered status value that changes once per clock.

Each bank is idle, open (activated), read-bursting or write-bursting. A read or write keeps its bank bursting for `BURST_CYC` cycles. When the burst ends, the bank returns to open, or to idle if A10 asked for auto-precharge. An illegal command raises a one-cycle flag and has no other effect. Burst time still runs on during that cycle. Power-down is tracked from clock-enable, and while it lasts the strobes are ignored.

Top module: `ddr_cmd_checker`

## Requirements
- R1: A synchronous active-high reset makes every bank idle and sets the outputs to cmd_code=1 (no-op), cmd_bank=0, auto_pre=0, illegal=0 and pwr_down=0. After reset, a read to any bank is illegal.
- R2: Inputs sampled at edge k appear on the outputs after edge k. Outside power-down and with cke high, the strobes decode as follows. cs_n=1 gives deselect (0). With cs_n=0, {ras_n,cas_n,we_n} decodes as: 111 no-op (1), 011 activate (2), 101 read (3), 100 write (4), 010 precharge (5), 001 refresh (6), 000 mode set, 110 burst stop (9). cmd_bank always echoes the sampled ba. Code 15 is reserved and is never produced.
- R3: Activate is legal only when the target bank is idle, and it opens that bank.
- R4: A read or write to an idle bank is illegal. auto_pre is set for a read or write sampled with a10=1, and is 0 for every other command.
- R5: A legal read or write keeps its bank bursting for the next BURST_CYC sampled commands. Deselect and no-op do not disturb this. The bank then becomes open, or idle if the command carried a10=1.
- R6: A legal read or write ends the burst of every other bank at once. Each of those banks then completes as in R5.
- R7: Precharge is always legal. With a10=1 it idles all banks. With a10=0 it idles only bank ba.
- R8: Refresh is legal only when all banks are idle.
- R9: The all-low mode set decodes to 7 when ba[0]=0 and to 8 when ba[0]=1, and is legal only when all banks are idle. With ba[1]=1 the combination is undefined and decodes as no-op (1).
- R10: Burst stop (9) is legal only while a bank is read-bursting and no bank is write-bursting. It ends the read burst.
- R11: cke sampled low outside power-down gives entry (10). Entry is illegal while any bank is bursting, and a legal entry sets pwr_down. While powered down, cke low gives no-op (1) and cke high gives exit (11), which clears pwr_down. Strobes are ignored in all three cases.
- R12: illegal is a one-cycle pulse that applies to the command sampled at that edge. An illegal command changes no bank state and no power-down state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all pins are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable |
| ba | input | BA_W | Bank address |
| a10 | input | 1 | Auto-precharge / precharge-all select |
| cmd_code | output | 4 | Decoded command code |
| cmd_bank | output | BA_W | Bank address of the decoded command |
| auto_pre | output | 1 | Read or write with auto-precharge |
| pwr_down | output | 1 | Device is in power-down |
| illegal | output | 1 | Command not allowed in the present state |

## Verification
No port shows bank state directly, so a wrong internal state appears only on the illegal flag or on the power-down output. It shows there on the first command whose legality depends on that state. A bank that ends its burst too early or too late is caught by a burst stop, activate or read probe placed at the exact boundary cycle. A missed truncation, precharge-all or auto-precharge is exposed by the next activate or read to the affected bank, one cycle after that command is sampled. The bench keeps its own model of bank and power-down state and checks every output on every cycle, so any divergence is reported within one cycle of the first command that reveals it.

// File: rtl/ddr_cmd_pkg.sv
package ddr_cmd_pkg;
  typedef enum logic [3:0] {
    CMD_DESEL = 4'd0,
    CMD_NOP   = 4'd1,
    CMD_ACT   = 4'd2,
    CMD_RD    = 4'd3,
    CMD_WR    = 4'd4,
    CMD_PRE   = 4'd5,
    CMD_REF   = 4'd6,
    CMD_MRS   = 4'd7,
    CMD_EMRS  = 4'd8,
    CMD_BST   = 4'd9,
    CMD_PDE   = 4'd10,
    CMD_PDX   = 4'd11,
    CMD_RSVD  = 4'd15
  } cmd_e;

  typedef enum logic [1:0] {
    BK_IDLE = 2'd0,
    BK_OPEN = 2'd1,
    BK_RD   = 2'd2,
    BK_WR   = 2'd3
  } bank_st_e;
endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
  import ddr_cmd_pkg::*;
(
  input  logic       cs_n,
  input  logic       ras_n,
  input  logic       cas_n,
  input  logic       we_n,
  input  logic       cke,
  input  logic [1:0] mode_sel,
  input  logic       pd_q,
  output cmd_e       cmd
);
  always_comb begin
    if (pd_q) begin
      cmd = cke ? CMD_PDX : CMD_NOP;
    end else if (!cke) begin
      cmd = CMD_PDE;
    end else if (cs_n) begin
      cmd = CMD_DESEL;
    end else begin
      unique case ({ras_n, cas_n, we_n})
        3'b111:  cmd = CMD_NOP;
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b010:  cmd = CMD_PRE;
        3'b001:  cmd = CMD_REF;
        3'b110:  cmd = CMD_BST;
        default: cmd = mode_sel[1] ? CMD_NOP : (mode_sel[0] ? CMD_EMRS : CMD_MRS);
      endcase
    end
  end
endmodule

// File: rtl/ddr_cmd_rules.sv
module ddr_cmd_rules
  import ddr_cmd_pkg::*;
#(
  parameter int NB = 4
) (
  input  cmd_e          cmd,
  input  logic          tgt_idle,
  input  logic [NB-1:0] idle_v,
  input  logic [NB-1:0] rd_v,
  input  logic [NB-1:0] wr_v,
  output logic          legal
);
  logic all_idle, any_rd, any_wr;

  assign all_idle = &idle_v;
  assign any_rd   = |rd_v;
  assign any_wr   = |wr_v;

  always_comb begin
    unique case (cmd)
      CMD_ACT:                   legal = tgt_idle;
      CMD_RD, CMD_WR:            legal = !tgt_idle;
      CMD_REF, CMD_MRS, CMD_EMRS: legal = all_idle;
      CMD_BST:                   legal = any_rd && !any_wr;
      CMD_PDE:                   legal = !(any_rd || any_wr);
      default:                   legal = 1'b1;
    endcase
  end
endmodule

// File: rtl/ddr_bank_fsm.sv
module ddr_bank_fsm
  import ddr_cmd_pkg::*;
#(
  parameter int BURST_CYC = 4
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     open_i,
  input  logic     pre_i,
  input  logic     start_i,
  input  logic     is_wr_i,
  input  logic     ap_i,
  input  logic     cut_i,
  output bank_st_e st_o
);
  localparam int CNT_W = $clog2(BURST_CYC + 1);

  bank_st_e       st_q;
  logic           ap_q;
  logic [CNT_W-1:0] cnt_q;
  logic           bursting;

  assign bursting = (st_q == BK_RD) || (st_q == BK_WR);
  assign st_o     = st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= BK_IDLE;
      ap_q  <= 1'b0;
      cnt_q <= '0;
    end else if (pre_i) begin
      st_q <= BK_IDLE;
    end else if (open_i) begin
      st_q <= BK_OPEN;
    end else if (start_i) begin
      st_q  <= is_wr_i ? BK_WR : BK_RD;
      ap_q  <= ap_i;
      cnt_q <= CNT_W'(BURST_CYC);
    end else if (bursting && (cut_i || cnt_q == CNT_W'(1))) begin
      st_q <= ap_q ? BK_IDLE : BK_OPEN;
    end else if (bursting) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/ddr_cmd_checker.sv
module ddr_cmd_checker
  import ddr_cmd_pkg::*;
#(
  parameter int BA_W      = 2,
  parameter int BURST_CYC = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cs_n,
  input  logic            ras_n,
  input  logic            cas_n,
  input  logic            we_n,
  input  logic            cke,
  input  logic [BA_W-1:0] ba,
  input  logic            a10,
  output logic [3:0]      cmd_code,
  output logic [BA_W-1:0] cmd_bank,
  output logic            auto_pre,
  output logic            pwr_down,
  output logic            illegal
);
  localparam int NB = 1 << BA_W;

  cmd_e          cmd_now;
  logic          legal;
  logic [NB-1:0] idle_v, rd_v, wr_v;
  logic          is_rdwr;

  ddr_cmd_decode u_decode (
    .cs_n     (cs_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .cke      (cke),
    .mode_sel (ba[1:0]),
    .pd_q     (pwr_down),
    .cmd      (cmd_now)
  );

  ddr_cmd_rules #(.NB(NB)) u_rules (
    .cmd      (cmd_now),
    .tgt_idle (idle_v[ba]),
    .idle_v   (idle_v),
    .rd_v     (rd_v),
    .wr_v     (wr_v),
    .legal    (legal)
  );

  assign is_rdwr = (cmd_now == CMD_RD) || (cmd_now == CMD_WR);

  for (genvar b = 0; b < NB; b++) begin : g_bank
    bank_st_e st;
    logic     hit;

    assign hit = (ba == BA_W'(b));

    ddr_bank_fsm #(.BURST_CYC(BURST_CYC)) u_fsm (
      .clk     (clk),
      .rst     (rst),
      .open_i  (legal && cmd_now == CMD_ACT && hit),
      .pre_i   (cmd_now == CMD_PRE && (a10 || hit)),
      .start_i (legal && is_rdwr && hit),
      .is_wr_i (cmd_now == CMD_WR),
      .ap_i    (a10),
      .cut_i   (legal && ((is_rdwr && !hit) || cmd_now == CMD_BST)),
      .st_o    (st)
    );

    assign idle_v[b] = (st == BK_IDLE);
    assign rd_v[b]   = (st == BK_RD);
    assign wr_v[b]   = (st == BK_WR);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_code <= CMD_NOP;
      cmd_bank <= '0;
      auto_pre <= 1'b0;
      pwr_down <= 1'b0;
      illegal  <= 1'b0;
    end else begin
      cmd_code <= cmd_now;
      cmd_bank <= ba;
      auto_pre <= is_rdwr && a10;
      illegal  <= !legal;
      if (legal && cmd_now == CMD_PDE) pwr_down <= 1'b1;
      else if (cmd_now == CMD_PDX)     pwr_down <= 1'b0;
    end
  end
endmodule

// File: rtl/ddr_cmd_checker_sva.sv
module ddr_cmd_checker_sva
  import ddr_cmd_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic [3:0] cmd_code,
  input logic       auto_pre,
  input logic       pwr_down,
  input logic       illegal
);
  AST_AP_ONLY_RDWR: assert property (@(posedge clk) disable iff (rst)
    auto_pre |-> (cmd_code == CMD_RD || cmd_code == CMD_WR)); // R4

  AST_PD_ENTRY: assert property (@(posedge clk) disable iff (rst)
    $rose(pwr_down) |-> (cmd_code == CMD_PDE && !illegal)); // R11

  AST_PD_EXIT: assert property (@(posedge clk) disable iff (rst)
    $fell(pwr_down) |-> (cmd_code == CMD_PDX)); // R11

  AST_PD_QUIET: assert property (@(posedge clk) disable iff (rst)
    pwr_down |-> (cmd_code == CMD_PDE || cmd_code == CMD_NOP)); // R11

  AST_ILLEGAL_SCOPE: assert property (@(posedge clk) disable iff (rst)
    illegal |-> !(cmd_code == CMD_DESEL || cmd_code == CMD_NOP ||
                  cmd_code == CMD_PRE || cmd_code == CMD_PDX)); // R12

  AST_NO_RESERVED: assert property (@(posedge clk) disable iff (rst)
    cmd_code != CMD_RSVD); // R2
endmodule

bind ddr_cmd_checker ddr_cmd_checker_sva u_sva (
  .clk      (clk),
  .rst      (rst),
  .cmd_code (cmd_code),
  .auto_pre (auto_pre),
  .pwr_down (pwr_down),
  .illegal  (illegal)
);

// File: tb/ddr_cmd_checker_bench.sv
module ddr_cmd_checker_bench;
  localparam int BC = 4;

  logic clk = 0, rst = 1;
  logic cs_n = 1, ras_n = 1, cas_n = 1, we_n = 1, cke = 1, a10 = 0;
  logic [1:0] ba = 0;
  logic [3:0] cmd_code;
  logic [1:0] cmd_bank;
  logic auto_pre, pwr_down, illegal;

  int total = 0, bad = 0;
  bit finished = 0;

  // bench model: 0 idle, 1 open, 2 read burst, 3 write burst
  int mst[4], mcnt[4];
  bit map_[4];
  bit mpd;
  int e_cmd; bit e_ap, e_ill;

  always #4 clk = ~clk;

  ddr_cmd_checker #(.BA_W(2), .BURST_CYC(BC)) u_ddr_cmd_checker (
    .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .cke(cke), .ba(ba), .a10(a10), .cmd_code(cmd_code),
    .cmd_bank(cmd_bank), .auto_pre(auto_pre), .pwr_down(pwr_down),
    .illegal(illegal)
  );

  function automatic int decode_cmd(bit c, bit r, bit ca, bit w, bit k, logic [1:0] b, bit pd);
    if (pd) return k ? 11 : 1;
    if (!k) return 10;
    if (c) return 0;
    case ({r, ca, w})
      3'b111: return 1;
      3'b011: return 2;
      3'b101: return 3;
      3'b100: return 4;
      3'b010: return 5;
      3'b001: return 6;
      3'b110: return 9;
      default: return b[1] ? 1 : (b[0] ? 8 : 7);
    endcase
  endfunction

  task automatic end_burst(int b);
    mst[b] = map_[b] ? 0 : 1;
  endtask

  task automatic model_step();
    bit all_idle = 1, any_rd = 0, any_wr = 0, legal;
    for (int b = 0; b < 4; b++) begin
      if (mst[b] != 0) all_idle = 0;
      if (mst[b] == 2) any_rd = 1;
      if (mst[b] == 3) any_wr = 1;
    end
    e_cmd = decode_cmd(cs_n, ras_n, cas_n, we_n, cke, ba, mpd);
    case (e_cmd)
      2: legal = (mst[ba] == 0);
      3, 4: legal = (mst[ba] != 0);
      6, 7, 8: legal = all_idle;
      9: legal = any_rd && !any_wr;
      10: legal = !(any_rd || any_wr);
      default: legal = 1;
    endcase
    e_ill = !legal;
    e_ap = a10 && (e_cmd == 3 || e_cmd == 4);
    for (int b = 0; b < 4; b++)
      if (mst[b] >= 2) begin
        if (mcnt[b] == 1) end_burst(b); else mcnt[b]--;
      end
    if (e_cmd == 5) begin
      for (int b = 0; b < 4; b++) if (a10 || ba == b) mst[b] = 0;
    end
    if (legal) begin
      case (e_cmd)
        2: mst[ba] = 1;
        3, 4: begin
          for (int b = 0; b < 4; b++)
            if (b != ba && mst[b] >= 2) end_burst(b);
          mst[ba] = (e_cmd == 4) ? 3 : 2; mcnt[ba] = BC; map_[ba] = a10;
        end
        9: for (int b = 0; b < 4; b++) if (mst[b] == 2) end_burst(b);
        10: mpd = 1;
        default: ;
      endcase
    end
    if (e_cmd == 11) mpd = 0;
  endtask

  task automatic compare(string tag);
    total++;
    if (cmd_code !== 4'(e_cmd) || cmd_bank !== ba || auto_pre !== e_ap ||
        illegal !== e_ill || pwr_down !== mpd) begin
      bad++;
      $display("FAIL %s: got cmd=%0d bank=%0d ap=%0d ill=%0d pd=%0d exp cmd=%0d bank=%0d ap=%0d ill=%0d pd=%0d",
               tag, cmd_code, cmd_bank, auto_pre, illegal, pwr_down,
               e_cmd, ba, e_ap, e_ill, mpd);
    end
  endtask

  // one cycle: drive after the falling edge, sample 2 ns after the rising edge
  task automatic cyc(bit c, bit r, bit ca, bit w, bit k, logic [1:0] b, bit a, string tag);
    @(negedge clk);
    cs_n = c; ras_n = r; cas_n = ca; we_n = w; cke = k; ba = b; a10 = a;
    @(posedge clk); #2;
    model_step();
    compare(tag);
  endtask

  task automatic op(int code, logic [1:0] b, bit a, string tag);
    case (code)
      0: cyc(1, 1, 1, 1, 1, b, a, tag);
      1: cyc(0, 1, 1, 1, 1, b, a, tag);
      2: cyc(0, 0, 1, 1, 1, b, a, tag);
      3: cyc(0, 1, 0, 1, 1, b, a, tag);
      4: cyc(0, 1, 0, 0, 1, b, a, tag);
      5: cyc(0, 0, 1, 0, 1, b, a, tag);
      6: cyc(0, 0, 0, 1, 1, b, a, tag);
      7: cyc(0, 0, 0, 0, 1, b, a, tag);
      9: cyc(0, 1, 1, 0, 1, b, a, tag);
      default: cyc(0, 0, 0, 0, 0, b, a, tag); // cke low, strobes ignored
    endcase
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: got hung exp finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int b = 0; b < 4; b++) begin mst[b] = 0; mcnt[b] = 0; map_[b] = 0; end
    mpd = 0;
    repeat (3) @(posedge clk);
    #2;
    total++;
    if (cmd_code !== 4'd1 || cmd_bank !== 2'd0 || auto_pre || illegal || pwr_down) begin
      bad++;
      $display("FAIL R1: got cmd=%0d bank=%0d ap=%0d ill=%0d pd=%0d exp 1 0 0 0 0",
               cmd_code, cmd_bank, auto_pre, illegal, pwr_down);
    end
    @(negedge clk); rst = 0;

    op(3, 2'd1, 0, "R1");          // read after reset: illegal
    op(0, 2'd0, 0, "R2");
    op(2, 2'd0, 0, "R3");          // open bank 0
    op(2, 2'd0, 0, "R3");          // reopen: illegal
    op(1, 2'd0, 0, "R12");         // nothing changed: next read legal
    op(4, 2'd0, 0, "R4");          // write burst on bank 0
    op(9, 2'd0, 0, "R10");         // stop during write: illegal
    op(3, 2'd1, 0, "R4");          // read to idle bank 1: illegal
    op(2, 2'd1, 0, "R3");
    op(3, 2'd1, 1, "R6");          // read bank 1 with ap, cuts bank 0 write
    op(9, 2'd0, 0, "R10");         // legal stop, bank 1 goes idle (ap)
    op(3, 2'd1, 0, "R5");          // illegal, bank 1 idle
    op(3, 2'd0, 0, "R6");          // bank 0 still open
    for (int i = 0; i < BC; i++) op(1, 2'd0, 0, "R5");
    op(9, 2'd0, 0, "R5");          // burst over: stop illegal
    op(7, 2'd0, 0, "R9");          // mode set with bank open: illegal
    op(6, 2'd0, 0, "R8");          // refresh with bank open: illegal
    op(5, 2'd3, 0, "R7");          // single precharge of bank 3 only
    op(3, 2'd0, 0, "R7");          // bank 0 still open
    op(5, 2'd2, 1, "R7");          // precharge all
    op(3, 2'd0, 0, "R7");          // illegal now
    op(7, 2'd0, 0, "R9");
    op(7, 2'd1, 0, "R9");          // extended
    op(7, 2'd2, 0, "R9");          // undefined -> no-op
    op(6, 2'd0, 0, "R8");
    op(10, 2'd0, 0, "R11");        // power-down entry
    op(10, 2'd0, 0, "R11");
    op(1, 2'd0, 0, "R11");         // exit
    op(2, 2'd2, 0, "R3");
    op(4, 2'd2, 1, "R4");
    op(10, 2'd0, 0, "R11");        // entry while bursting: illegal
    for (int i = 0; i < BC; i++) op(0, 2'd0, 0, "R5");
    op(2, 2'd2, 0, "R5");          // write ap done: bank 2 idle again

    for (int n = 0; n < 4000; n++) begin
      int k = $urandom % 20;
      logic [1:0] b = 2'($urandom);
      bit a = ($urandom % 4) == 0;
      if (mpd) op(($urandom % 2) ? 1 : 10, b, a, "R2");
      else if (k < 2) op(0, b, a, "R2");
      else if (k < 4) op(1, b, a, "R2");
      else if (k < 7) op(2, b, a, "R3");
      else if (k < 10) op(3, b, a, "R4");
      else if (k < 12) op(4, b, a, "R5");
      else if (k < 14) op(5, b, a, "R7");
      else if (k < 15) op(6, b, a, "R8");
      else if (k < 16) op(7, b, a, "R9");
      else if (k < 18) op(9, b, a, "R10");
      else op(10, b, a, "R11");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule